// File: doc/BRIEF.md
# Masked Address Breakpoint Unit

This block sits next to a CPU core and watches two address streams: the instruction fetch address and the load/store address. It holds one execute breakpoint and one data-access breakpoint. Each is a reference address paired with a mask. An access matches when the address ANDed with the mask equals the reference. A control register arms each breakpoint. For data accesses it also selects whether reads, writes or both may trigger.

When an armed match occurs, the block raises a breakpoint request in the same cycle as the access. It also supplies the fixed address that the core jumps to on a breakpoint. A two-bit sticky status records which breakpoint kind has fired since software last cleared it. All registers are reached through a small index-addressed port with a single-cycle write strobe and a combinational read.

Top module: `bkpt_unit`

## Requirements
- R1: With control bit 24 set, a valid fetch whose address ANDed with the execute mask (index 1) equals the execute reference (index 0) raises `brk_req` in the same cycle; a non-matching or invalid fetch does not.
- R2: With control bit 25 set and the matching type enable set, a valid data access whose address ANDed with the data mask (index 3) equals the data reference (index 2) raises `brk_req` in the same cycle; a non-matching address does not.
- R3: A matching read (`dacc_write`=0) triggers only when control bit 26 is set. A matching write (`dacc_write`=1) triggers only when control bit 27 is set. A matching access of a disabled type gives no request.
- R4: With bit 24 clear no fetch triggers. With bit 25 clear no data access triggers, whatever bits 26 and 27 hold.
- R5: Both breakpoints may be armed together. Simultaneous matches give one request, and `brk_req` is high only in the cycles that hold a qualifying access (a pulse, not a level).
- R6: The status register (index 5) reads bit 0 = execute fired and bit 1 = data fired. The bits stay set until any write to index 5 clears them. A hit in the same cycle as the clearing write is kept.
- R7: `brk_vector` always reads 0x00000040.
- R8: Indices 0 to 3 read back the full written word. Index 4 returns only bits 27:24, with the other bits zero. Indices 6 and 7 read zero and ignore writes. A write takes effect from the next cycle, so an access in the write cycle is compared against the old value.
- R9: After reset every register and the status read as zero, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_idx` |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_pc | input | 32 | Fetch address |
| dacc_valid | input | 1 | Load/store address is valid this cycle |
| dacc_write | input | 1 | 1 = store, 0 = load |
| dacc_addr | input | 32 | Load/store address |
| brk_req | output | 1 | Breakpoint request, same cycle as the access |
| brk_vector | output | 32 | Debug vector address |

## Verification
The assertions assume that `fetch_valid` and `dacc_valid` are driven to known values every cycle after reset. They also assume that `dacc_write` and the addresses are known whenever their valid is high. Register writes are assumed to be single-cycle strobes with a known index. The bench changes inputs only on the falling clock edge and holds every input at a defined level from time zero, so these assumptions are never broken.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
    // Register indices on the configuration port
    localparam int IDX_EXEC_ADDR = 0;
    localparam int IDX_EXEC_MASK = 1;
    localparam int IDX_DATA_ADDR = 2;
    localparam int IDX_DATA_MASK = 3;
    localparam int IDX_CTRL      = 4;
    localparam int IDX_STATUS    = 5;

    // Control field: four bits starting at bit 24
    localparam int CTRL_LSB  = 24;
    localparam int CTRL_W    = 4;
    localparam int CTL_EXEC  = 0; // bit 24
    localparam int CTL_DATA  = 1; // bit 25
    localparam int CTL_RD    = 2; // bit 26
    localparam int CTL_WR    = 3; // bit 27

    // Breakpoint channels
    localparam int CH_EXEC   = 0;
    localparam int CH_DATA   = 1;
    localparam int NUM_CH    = 2;

    localparam logic [31:0] DEBUG_VECTOR = 32'h0000_0040;
endpackage

// File: rtl/bkpt_cmp.sv
module bkpt_cmp #(
    parameter int AW = 32
) (
    input  logic          valid,
    input  logic          arm,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ref_addr,
    input  logic [AW-1:0] ref_mask,
    output logic          hit
);
    logic [AW-1:0] masked;

    always_comb begin
        masked = addr & ref_mask;
        hit    = valid && arm && (masked == ref_addr);
    end
endmodule

// File: rtl/bkpt_qual.sv
module bkpt_qual
    import bkpt_pkg::*;
(
    input  logic [CTRL_W-1:0] ctl,
    input  logic              is_write,
    output logic [NUM_CH-1:0] arm
);
    always_comb begin
        arm          = '0;
        arm[CH_EXEC] = ctl[CTL_EXEC];
        // data breakpoint needs its enable plus the enable for this access type
        arm[CH_DATA] = ctl[CTL_DATA] && (is_write ? ctl[CTL_WR] : ctl[CTL_RD]);
    end
endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IDX_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [IDX_W-1:0]           idx,
    input  logic [AW-1:0]              wdata,
    input  logic [NUM_CH-1:0]          hit,
    output logic [AW-1:0]              rdata,
    output logic [NUM_CH-1:0][AW-1:0]  ref_addr,
    output logic [NUM_CH-1:0][AW-1:0]  ref_mask,
    output logic [CTRL_W-1:0]          ctl_q,
    output logic [NUM_CH-1:0]          sticky_q
);
    localparam logic [IDX_W-1:0] I_CTRL   = IDX_W'(IDX_CTRL);
    localparam logic [IDX_W-1:0] I_STATUS = IDX_W'(IDX_STATUS);

    typedef struct packed {
        logic [NUM_CH-1:0][AW-1:0] addr;
        logic [NUM_CH-1:0][AW-1:0] mask;
        logic [CTRL_W-1:0]         ctl;
        logic [NUM_CH-1:0]         sticky;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (idx == IDX_W'(2 * ch))     st_d.addr[ch] = wdata;
                if (idx == IDX_W'(2 * ch + 1)) st_d.mask[ch] = wdata;
            end
            if (idx == I_CTRL)   st_d.ctl    = wdata[CTRL_LSB +: CTRL_W];
            if (idx == I_STATUS) st_d.sticky = '0;
        end
        // a hit in the clearing cycle survives
        st_d.sticky = st_d.sticky | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (idx == IDX_W'(2 * ch))     rdata = st_q.addr[ch];
            if (idx == IDX_W'(2 * ch + 1)) rdata = st_q.mask[ch];
        end
        if (idx == I_CTRL)   rdata[CTRL_LSB +: CTRL_W] = st_q.ctl;
        if (idx == I_STATUS) rdata[NUM_CH-1:0]         = st_q.sticky;
    end

    assign ref_addr = st_q.addr;
    assign ref_mask = st_q.mask;
    assign ctl_q    = st_q.ctl;
    assign sticky_q = st_q.sticky;
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [AW-1:0]    cfg_wdata,
    output logic [AW-1:0]    cfg_rdata,
    input  logic             fetch_valid,
    input  logic [AW-1:0]    fetch_pc,
    input  logic             dacc_valid,
    input  logic             dacc_write,
    input  logic [AW-1:0]    dacc_addr,
    output logic             brk_req,
    output logic [AW-1:0]    brk_vector
);
    logic [NUM_CH-1:0][AW-1:0] ref_addr;
    logic [NUM_CH-1:0][AW-1:0] ref_mask;
    logic [CTRL_W-1:0]         ctl_q;
    logic [NUM_CH-1:0]         sticky_q;
    logic [NUM_CH-1:0]         arm;
    logic [NUM_CH-1:0]         hit;
    logic [NUM_CH-1:0]         ch_valid;
    logic [NUM_CH-1:0][AW-1:0] ch_addr;

    assign ch_valid[CH_EXEC] = fetch_valid;
    assign ch_valid[CH_DATA] = dacc_valid;
    assign ch_addr[CH_EXEC]  = fetch_pc;
    assign ch_addr[CH_DATA]  = dacc_addr;

    bkpt_regs #(.AW(AW), .IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .idx      (cfg_idx),
        .wdata    (cfg_wdata),
        .hit      (hit),
        .rdata    (cfg_rdata),
        .ref_addr (ref_addr),
        .ref_mask (ref_mask),
        .ctl_q    (ctl_q),
        .sticky_q (sticky_q)
    );

    bkpt_qual u_qual (
        .ctl      (ctl_q),
        .is_write (dacc_write),
        .arm      (arm)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
        bkpt_cmp #(.AW(AW)) u_cmp (
            .valid    (ch_valid[ch]),
            .arm      (arm[ch]),
            .addr     (ch_addr[ch]),
            .ref_addr (ref_addr[ch]),
            .ref_mask (ref_mask[ch]),
            .hit      (hit[ch])
        );
    end

    assign brk_req    = |hit;
    assign brk_vector = AW'(DEBUG_VECTOR);
endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk #(
    parameter int AW    = 32,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [IDX_W-1:0] cfg_idx,
    input logic             fetch_valid,
    input logic [AW-1:0]    fetch_pc,
    input logic             dacc_valid,
    input logic             dacc_write,
    input logic             brk_req,
    input logic [AW-1:0]    exec_addr,
    input logic [AW-1:0]    exec_mask,
    input logic [3:0]       ctl_q,
    input logic [1:0]       sticky_q
);
    // R1
    exec_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && ctl_q[0] && ((fetch_pc & exec_mask) == exec_addr)) |-> brk_req);

    // R3
    write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && dacc_valid && dacc_write && !ctl_q[3]) |-> !brk_req);

    // R3
    read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && dacc_valid && !dacc_write && !ctl_q[2]) |-> !brk_req);

    // R4
    data_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && !ctl_q[1]) |-> !brk_req);

    // R4
    exec_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dacc_valid && !ctl_q[0]) |-> !brk_req);

    // R5
    pulse_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (fetch_valid || dacc_valid));

    // R6
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> (sticky_q != 2'b00));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q != 2'b00) && !(cfg_we && cfg_idx == IDX_W'(5)) |=> (sticky_q != 2'b00));
endmodule

bind bkpt_unit bkpt_unit_chk #(.AW(AW), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_idx     (cfg_idx),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .dacc_valid  (dacc_valid),
    .dacc_write  (dacc_write),
    .brk_req     (brk_req),
    .exec_addr   (ref_addr[0]),
    .exec_mask   (ref_mask[0]),
    .ctl_q       (ctl_q),
    .sticky_q    (sticky_q)
);

// File: tb/sim_bkpt_unit.sv
module sim_bkpt_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        dacc_valid = 1'b0;
    logic        dacc_write = 1'b0;
    logic [31:0] dacc_addr = '0;
    logic        brk_req;
    logic [31:0] brk_vector;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bkpt_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .dacc_valid(dacc_valid), .dacc_write(dacc_write), .dacc_addr(dacc_addr),
        .brk_req(brk_req), .brk_vector(brk_vector)
    );

    typedef struct packed {
        logic        fv;
        logic [31:0] pc;
        logic        dv;
        logic        dw;
        logic [31:0] da;
        logic        exp;
    } vec_t;

    // config: exec ref 0x1000 mask 0xFFFFF000, data ref 0x80000040 mask 0xFFFFFFF0, ctl bits 24,25,26
    localparam vec_t TBL [8] = '{
        '{1'b1, 32'h0000_1234, 1'b0, 1'b0, 32'h0,         1'b1}, // R1 match
        '{1'b1, 32'h0000_2000, 1'b0, 1'b0, 32'h0,         1'b0}, // R1 miss
        '{1'b0, 32'h0,         1'b1, 1'b0, 32'h8000_004C, 1'b1}, // R2 read match
        '{1'b0, 32'h0,         1'b1, 1'b0, 32'h8000_0050, 1'b0}, // R2 miss
        '{1'b0, 32'h0,         1'b1, 1'b1, 32'h8000_0044, 1'b0}, // R3 write disabled
        '{1'b1, 32'h0000_1FFC, 1'b1, 1'b0, 32'h8000_0040, 1'b1}, // R5 both
        '{1'b0, 32'h0000_1000, 1'b0, 1'b0, 32'h8000_0040, 1'b0}, // R5 no valid
        '{1'b0, 32'h0000_1000, 1'b1, 1'b1, 32'h0000_0040, 1'b0}  // R2 miss, write
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] idx, input logic [31:0] exp);
        cfg_idx = idx;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    // drive at negedge, sample 5 ns later, before the next rising edge
    task automatic access(input logic fv, input logic [31:0] pc, input logic dv,
                          input logic dw, input logic [31:0] da);
        @(negedge clk);
        fetch_valid = fv; fetch_pc = pc; dacc_valid = dv; dacc_write = dw; dacc_addr = da;
        #5;
    endtask

    task automatic idle();
        @(negedge clk);
        fetch_valid = 1'b0; dacc_valid = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        for (int i = 0; i < 8; i++) rd_chk("R9", 3'(i), 32'h0);
        check("R9", {31'h0, brk_req}, 32'h0);
        // R7
        check("R7", brk_vector, 32'h0000_0040);

        // configuration and R8 readback
        wr(3'd0, 32'h0000_1000);
        wr(3'd1, 32'hFFFF_F000);
        wr(3'd2, 32'h8000_0040);
        wr(3'd3, 32'hFFFF_FFF0);
        wr(3'd4, 32'hFFFF_FFFF);
        rd_chk("R8", 3'd0, 32'h0000_1000);
        rd_chk("R8", 3'd3, 32'hFFFF_FFF0);
        rd_chk("R8", 3'd4, 32'h0F00_0000);
        wr(3'd6, 32'h1234_5678);
        rd_chk("R8", 3'd6, 32'h0);
        wr(3'd4, 32'h0700_0000);
        rd_chk("R8", 3'd4, 32'h0700_0000);
        wr(3'd5, 32'h0);

        // vector table walk
        foreach (TBL[i]) begin
            access(TBL[i].fv, TBL[i].pc, TBL[i].dv, TBL[i].dw, TBL[i].da);
            check($sformatf("R1/R2/R3/R5 vec %0d", i), {31'h0, brk_req}, {31'h0, TBL[i].exp});
        end
        idle();
        // R6 both kinds recorded
        rd_chk("R6", 3'd5, 32'h3);
        wr(3'd5, 32'h0);
        rd_chk("R6", 3'd5, 32'h0);

        // R6 hit in the clearing cycle is kept
        access(1'b1, 32'h0000_1008, 1'b0, 1'b0, 32'h0);
        idle();
        rd_chk("R6", 3'd5, 32'h1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd5;
        dacc_valid = 1'b1; dacc_write = 1'b0; dacc_addr = 32'h8000_0048;
        @(negedge clk);
        cfg_we = 1'b0; dacc_valid = 1'b0;
        rd_chk("R6", 3'd5, 32'h2);

        // R3 write enable bit 27
        wr(3'd4, 32'h0A00_0000);
        access(1'b0, 32'h0, 1'b1, 1'b1, 32'h8000_0044);
        check("R3 write on", {31'h0, brk_req}, 32'h1);
        access(1'b0, 32'h0, 1'b1, 1'b0, 32'h8000_0044);
        check("R3 read off", {31'h0, brk_req}, 32'h0);
        idle();

        // R4 data enable clear with both type bits set
        wr(3'd4, 32'h0D00_0000);
        access(1'b0, 32'h0, 1'b1, 1'b1, 32'h8000_0044);
        check("R4 data off", {31'h0, brk_req}, 32'h0);
        access(1'b1, 32'h0000_1004, 1'b0, 1'b0, 32'h0);
        check("R4 exec on", {31'h0, brk_req}, 32'h1);
        idle();
        wr(3'd4, 32'h0E00_0000);
        access(1'b1, 32'h0000_1004, 1'b0, 1'b0, 32'h0);
        check("R4 exec off", {31'h0, brk_req}, 32'h0);
        idle();

        // R8 write takes effect next cycle
        wr(3'd4, 32'h0100_0000);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd0; cfg_wdata = 32'h0000_3000;
        fetch_valid = 1'b1; fetch_pc = 32'h0000_3000;
        #5;
        check("R8 old value", {31'h0, brk_req}, 32'h0);
        @(negedge clk);
        cfg_we = 1'b0;
        #5;
        check("R8 new value", {31'h0, brk_req}, 32'h1);
        idle();

        // R9 reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk("R9", 3'd0, 32'h0);
        rd_chk("R9", 3'd4, 32'h0);
        rd_chk("R9", 3'd5, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule